// File: doc/BRIEF.md
# Masked Packed Vector OR Unit

This execution lane ORs two packed operands for a 512-bit vector register file. Each operand is split into 64-bit elements. The lane works on 2, 4 or 8 elements, matching a vector length of 128, 256 or 512 bits. The bits are treated only as a logic pattern. No floating-point interpretation, NaN handling or exception applies.

An encoding class input selects the operand form:
- **Class 0, legacy:** a two-operand form in which the old destination is also the first source.
- **Class 1, plain:** a three-operand form with no masking.
- **Class 2, masked:** a three-operand form with a per-element writemask, merging or zeroing, and broadcast of one 64-bit scalar.

The class also sets what happens to destination bits above the active length. Those bits are either cleared or kept.

The caller supplies both sources, the old destination and any broadcast scalar, already loaded. The lane returns the full 512-bit destination one clock later, together with a write strobe and an error flag for illegal combinations.

Top module: `vor_unit`

## Requirements
- R1: While reset is asserted, and after it, `out_valid`, `out_error`, `out_wr` and `dest_out` are all 0 until a valid input arrives. `out_valid` is 1 exactly one cycle after a cycle with `in_valid`=1, and 0 otherwise. `dest_out` holds its value while no valid input arrives.
- R2: Vector length codes are 0 for 128 bits, 1 for 256 bits and 2 for 512 bits. For class 1 (plain), every element j below the element count (2 or 4) becomes `src1[j]` OR `src2[j]`, where element j is bits [64j+63:64j].
- R3: For class 2 (masked), element j takes the OR result when `mask_en`=0 or when `wmask[j]`=1.
- R4: For class 2, a masked-off element becomes 0 when `zero_mode`=1. When `zero_mode`=0 it keeps the `dest_old` element.
- R5: For class 2, when `bcast`=1 and `src2_mem`=1, every element is ORed with `src2[63:0]`. When `bcast`=1 and `src2_mem`=0, the full `src2` is used.
- R6: For classes 1 and 2, every destination bit from the vector length up to bit 511 is 0.
- R7: For class 0 (legacy), `dest_old` is the first source and `src1` is ignored. The operation covers elements 0 and 1 at length code 0 or 1. Bits 511:128 equal `dest_old`.
- R8: The following combinations are illegal: length code 2 with class 0 or class 1, length code 3, and class code 3. An illegal combination gives `out_error`=1, `out_wr`=0 and `dest_out` equal to `dest_old`.
- R9: Writemask bits at or above the active element count have no effect on `dest_out`.
- R10: `out_wr` is 1 exactly when `out_valid`=1 and `out_error`=0.
- R11: For classes 0 and 1, the inputs `mask_en`, `wmask`, `zero_mode`, `bcast` and `src2_mem` have no effect on `dest_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| enc_class | input | 2 | 0 legacy, 1 plain, 2 masked |
| vlen_sel | input | 2 | 0: 128 bits, 1: 256 bits, 2: 512 bits |
| src1 | input | 512 | First source |
| src2 | input | 512 | Second source; bits [63:0] hold the broadcast scalar |
| dest_old | input | 512 | Current destination value |
| mask_en | input | 1 | Writemask in use |
| wmask | input | 8 | Per-element writemask |
| zero_mode | input | 1 | 1 zeroing, 0 merging |
| bcast | input | 1 | Broadcast requested |
| src2_mem | input | 1 | Second source comes from memory |
| out_valid | output | 1 | Result valid |
| out_error | output | 1 | Illegal combination seen |
| out_wr | output | 1 | Destination write strobe |
| dest_out | output | 512 | Full destination result |

## Verification
Each result is due one clock after the cycle that carries the stimulus. This applies to the data, the error flag and the strobe alike, since one register stage sits on every path. The bench drives inputs on the falling edge and works out the expected outputs at that same moment. It compares them on the next falling edge, half a period after the capturing rising edge. Idle cycles are compared too, which confirms that the held destination and the dropped valid appear on that same one-cycle schedule.

// File: rtl/vor_pkg.sv
package vor_pkg;
    typedef enum logic [1:0] {
        CLS_LEGACY = 2'd0,
        CLS_PLAIN  = 2'd1,
        CLS_MASKED = 2'd2,
        CLS_BAD    = 2'd3
    } cls_e;

    localparam logic [1:0] LEN_SHORT = 2'd0;
    localparam logic [1:0] LEN_MID   = 2'd1;
    localparam logic [1:0] LEN_FULL  = 2'd2;
    localparam logic [1:0] LEN_BAD   = 2'd3;
endpackage

// File: rtl/vor_lane_ctrl.sv
module vor_lane_ctrl
    import vor_pkg::*;
#(
    parameter int NUM_ELEM = 8
) (
    input  cls_e                cls,
    input  logic [1:0]          vlen_sel,
    input  logic                mask_en,
    input  logic [NUM_ELEM-1:0] wmask,
    output logic [NUM_ELEM-1:0] active,
    output logic [NUM_ELEM-1:0] take,
    output logic                clear_upper,
    output logic                legacy,
    output logic                illegal
);
    localparam int CNT_SHORT = NUM_ELEM / 4;
    localparam int CNT_MID   = NUM_ELEM / 2;
    localparam int CNT_FULL  = NUM_ELEM;

    int cnt;

    always_comb begin
        legacy      = (cls == CLS_LEGACY);
        clear_upper = !legacy;
        illegal     = (cls == CLS_BAD) || (vlen_sel == LEN_BAD) ||
                      ((cls != CLS_MASKED) && (vlen_sel == LEN_FULL));
        if (legacy) begin
            cnt = CNT_SHORT;
        end else begin
            case (vlen_sel)
                LEN_SHORT: cnt = CNT_SHORT;
                LEN_MID:   cnt = CNT_MID;
                default:   cnt = CNT_FULL;
            endcase
        end
    end

    for (genvar j = 0; j < NUM_ELEM; j++) begin : g_ctl
        assign active[j] = (j < cnt);
        assign take[j]   = (cls != CLS_MASKED) || !mask_en || wmask[j];
    end
endmodule

// File: rtl/vor_elem.sv
module vor_elem #(
    parameter int EW = 64
) (
    input  logic [EW-1:0] a,
    input  logic [EW-1:0] b,
    input  logic [EW-1:0] old,
    input  logic          active,
    input  logic          take,
    input  logic          zero_mode,
    input  logic          clear_upper,
    output logic [EW-1:0] res
);
    always_comb begin
        if (active) begin
            if (take)           res = a | b;
            else if (zero_mode) res = '0;
            else                res = old;
        end else begin
            res = clear_upper ? '0 : old;
        end
    end
endmodule

// File: rtl/vor_unit.sv
module vor_unit
    import vor_pkg::*;
#(
    parameter int EW       = 64,
    parameter int NUM_ELEM = 8,
    parameter int VW       = EW * NUM_ELEM
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [1:0]          enc_class,
    input  logic [1:0]          vlen_sel,
    input  logic [VW-1:0]       src1,
    input  logic [VW-1:0]       src2,
    input  logic [VW-1:0]       dest_old,
    input  logic                mask_en,
    input  logic [NUM_ELEM-1:0] wmask,
    input  logic                zero_mode,
    input  logic                bcast,
    input  logic                src2_mem,
    output logic                out_valid,
    output logic                out_error,
    output logic                out_wr,
    output logic [VW-1:0]       dest_out
);
    typedef struct packed {
        logic          vld;
        logic          err;
        logic [VW-1:0] dest;
    } state_t;

    state_t st_d, st_q;

    cls_e                cls;
    logic [NUM_ELEM-1:0] active, take;
    logic                clear_upper, legacy, illegal, bcast_eff;
    logic [VW-1:0]       lane_res;

    assign cls       = cls_e'(enc_class);
    assign bcast_eff = (cls == CLS_MASKED) && bcast && src2_mem;

    vor_lane_ctrl #(.NUM_ELEM(NUM_ELEM)) u_ctrl (
        .cls         (cls),
        .vlen_sel    (vlen_sel),
        .mask_en     (mask_en),
        .wmask       (wmask),
        .active      (active),
        .take        (take),
        .clear_upper (clear_upper),
        .legacy      (legacy),
        .illegal     (illegal)
    );

    for (genvar j = 0; j < NUM_ELEM; j++) begin : g_lane
        logic [EW-1:0] a_j, b_j;
        assign a_j = legacy    ? dest_old[j*EW +: EW] : src1[j*EW +: EW];
        assign b_j = bcast_eff ? src2[EW-1:0]         : src2[j*EW +: EW];
        vor_elem #(.EW(EW)) u_elem (
            .a           (a_j),
            .b           (b_j),
            .old         (dest_old[j*EW +: EW]),
            .active      (active[j]),
            .take        (take[j]),
            .zero_mode   (zero_mode),
            .clear_upper (clear_upper),
            .res         (lane_res[j*EW +: EW])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        st_d.err = in_valid && illegal;
        if (in_valid) begin
            st_d.dest = illegal ? dest_old : lane_res;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_error = st_q.err;
    assign out_wr    = st_q.vld && !st_q.err;
    assign dest_out  = st_q.dest;
endmodule

// File: rtl/vor_unit_chk.sv
module vor_unit_chk #(
    parameter int EW       = 64,
    parameter int NUM_ELEM = 8,
    parameter int VW       = EW * NUM_ELEM
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic [1:0]          enc_class,
    input logic [1:0]          vlen_sel,
    input logic [VW-1:0]       dest_old,
    input logic                mask_en,
    input logic [NUM_ELEM-1:0] wmask,
    input logic                zero_mode,
    input logic                out_valid,
    input logic                out_error,
    input logic                out_wr,
    input logic [VW-1:0]       dest_out
);
    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R1
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R8
    bad_combo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && enc_class == 2'd0 && vlen_sel == 2'd2)
        |=> (out_error && !out_wr && dest_out == $past(dest_old)));

    // R7
    legacy_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && enc_class == 2'd0 && vlen_sel[1] == 1'b0)
        |=> (dest_out[VW-1:2*EW] == $past(dest_old[VW-1:2*EW])));

    // R6
    short_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && enc_class == 2'd2 && vlen_sel == 2'd0)
        |=> (dest_out[VW-1:2*EW] == '0));

    // R4
    all_zeroed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && enc_class == 2'd2 && vlen_sel != 2'd3 && mask_en &&
         zero_mode && wmask == '0)
        |=> (dest_out == '0));

    // R10
    strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_wr |-> (out_valid && !out_error));
endmodule

bind vor_unit vor_unit_chk #(.EW(EW), .NUM_ELEM(NUM_ELEM), .VW(VW)) u_chk (.*);

// File: tb/sim_vor_unit.sv
module sim_vor_unit;
    localparam int EW = 64;
    localparam int NE = 8;
    localparam int VW = EW * NE;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [1:0]    enc_class = '0;
    logic [1:0]    vlen_sel = '0;
    logic [VW-1:0] src1 = '0, src2 = '0, dest_old = '0;
    logic          mask_en = 1'b0;
    logic [NE-1:0] wmask = '0;
    logic          zero_mode = 1'b0, bcast = 1'b0, src2_mem = 1'b0;
    logic          out_valid, out_error, out_wr;
    logic [VW-1:0] dest_out;

    int checks = 0;
    int errors = 0;
    logic          e_vld = 1'b0, e_err = 1'b0;
    logic [VW-1:0] e_dest = '0;
    string         pend_tag = "R1";

    always #10 clk = ~clk;

    vor_unit #(.EW(EW), .NUM_ELEM(NE)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .enc_class(enc_class),
        .vlen_sel(vlen_sel), .src1(src1), .src2(src2), .dest_old(dest_old),
        .mask_en(mask_en), .wmask(wmask), .zero_mode(zero_mode), .bcast(bcast),
        .src2_mem(src2_mem), .out_valid(out_valid), .out_error(out_error),
        .out_wr(out_wr), .dest_out(dest_out)
    );

    function automatic logic [VW-1:0] rnd_vec();
        logic [VW-1:0] v;
        for (int k = 0; k < VW / 32; k++) v[k*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic check_now(string tag);
        checks++;
        if (out_valid !== e_vld || out_error !== e_err ||
            out_wr !== (e_vld && !e_err) || dest_out !== e_dest) begin
            errors++;
            $display("FAIL %s (R10 strobe incl.): got v=%0b e=%0b w=%0b d=%h exp v=%0b e=%0b w=%0b d=%h",
                     tag, out_valid, out_error, out_wr, dest_out,
                     e_vld, e_err, e_vld && !e_err, e_dest);
        end
    endtask

    // Behavioural expectation for the inputs currently driven.
    task automatic predict();
        bit bad;
        int cnt;
        logic [EW-1:0] a, b, r;
        if (!in_valid) begin
            e_vld = 1'b0;
            e_err = 1'b0;
            return;
        end
        e_vld = 1'b1;
        bad = (enc_class == 2'd3) || (vlen_sel == 2'd3) ||
              (enc_class != 2'd2 && vlen_sel == 2'd2);
        e_err = bad;
        if (bad) begin
            e_dest = dest_old;
            return;
        end
        cnt = (enc_class == 2'd0) ? 2 : (vlen_sel == 2'd0 ? 2 : (vlen_sel == 2'd1 ? 4 : 8));
        for (int j = 0; j < NE; j++) begin
            if (j < cnt) begin
                a = (enc_class == 2'd0) ? dest_old[j*EW +: EW] : src1[j*EW +: EW];
                b = (enc_class == 2'd2 && bcast && src2_mem) ? src2[EW-1:0] : src2[j*EW +: EW];
                if (enc_class != 2'd2 || !mask_en || wmask[j]) r = a | b;
                else if (zero_mode) r = '0;
                else r = dest_old[j*EW +: EW];
            end else begin
                r = (enc_class == 2'd0) ? dest_old[j*EW +: EW] : '0;
            end
            e_dest[j*EW +: EW] = r;
        end
    endtask

    task automatic step(input string tag, input bit v, input logic [1:0] c,
                        input logic [1:0] l, input bit me, input logic [NE-1:0] wm,
                        input bit zm, input bit bc, input bit mem);
        @(negedge clk);
        check_now(pend_tag);
        in_valid = v; enc_class = c; vlen_sel = l;
        src1 = rnd_vec(); src2 = rnd_vec(); dest_old = rnd_vec();
        mask_en = me; wmask = wm; zero_mode = zm; bcast = bc; src2_mem = mem;
        predict();
        pend_tag = tag;
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_now("R1 reset");
        rst_n = 1'b1;
        step("R2 plain 128 / R6",    1, 2'd1, 2'd0, 0, '0, 0, 0, 0);
        step("R2 plain 256 / R6",    1, 2'd1, 2'd1, 0, '0, 0, 0, 0);
        step("R1 idle hold",         0, 2'd1, 2'd1, 0, '0, 0, 0, 0);
        step("R3 R4 merge 512",      1, 2'd2, 2'd2, 1, 8'hA5, 0, 0, 0);
        step("R4 zero 512",          1, 2'd2, 2'd2, 1, 8'h5A, 1, 0, 0);
        step("R9 zero 256 hi bits",  1, 2'd2, 2'd1, 1, 8'hF2, 1, 0, 0);
        step("R9 merge 128 hi bits", 1, 2'd2, 2'd0, 1, 8'hFD, 0, 0, 0);
        step("R3 no mask",           1, 2'd2, 2'd2, 0, 8'h00, 1, 0, 0);
        step("R4 all zeroed",        1, 2'd2, 2'd1, 1, 8'h00, 1, 0, 0);
        step("R5 bcast mem",         1, 2'd2, 2'd2, 1, 8'h77, 0, 1, 1);
        step("R5 bcast reg",         1, 2'd2, 2'd2, 0, 8'h00, 0, 1, 0);
        step("R7 legacy 128",        1, 2'd0, 2'd0, 0, '0, 0, 0, 0);
        step("R7 legacy len1",       1, 2'd0, 2'd1, 0, '0, 0, 0, 0);
        step("R11 legacy noise",     1, 2'd0, 2'd0, 1, 8'h00, 1, 1, 1);
        step("R11 plain noise",      1, 2'd1, 2'd1, 1, 8'h00, 1, 1, 1);
        step("R8 legacy 512",        1, 2'd0, 2'd2, 0, '0, 0, 0, 0);
        step("R8 plain 512",         1, 2'd1, 2'd2, 0, '0, 0, 0, 0);
        step("R8 class 3",           1, 2'd3, 2'd0, 0, '0, 0, 0, 0);
        step("R8 length 3",          1, 2'd2, 2'd3, 0, '0, 0, 0, 0);
        step("R1 idle after error",  0, 2'd0, 2'd0, 0, '0, 0, 0, 0);
        for (int n = 0; n < 600; n++) begin
            step("random mix", ($urandom % 5) != 0, 2'($urandom), 2'($urandom),
                 1'($urandom), 8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
        end
        step("R1 final idle", 0, 2'd0, 2'd0, 0, '0, 0, 0, 0);
        @(negedge clk);
        check_now(pend_tag);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule